// File: doc/BRIEF.md
# Buffered Program Load Sequencer

This block watches a flash command bus and decodes the buffered-program command. After a two-write unlock, a load code written to any address of a sector picks the target sector. The next write to that sector gives the number of words to load, written as that number minus one. Each following write carries one word together with its address. The words collect in a local page buffer. A confirm write to the sector then raises a one-cycle programming request. The request comes with the base address of the page and with all of the page's words. Offsets that were never loaded read as all ones, which means they are left unprogrammed.

Every loaded address must fall inside the 16-word page that the first loaded address opened. A count above the page size, a write outside the page or the sector, or a wrong confirm code each put the block into an aborted state. The abort flag is then held high. Only a dedicated three-write reset sequence clears it, and until then every other command is ignored. The flash array itself sits outside this block and takes the request.

Top module: `wbuf_loader`

## Requirements
- R1: After a synchronous reset, `prog_start` and `aborted` are low and every word of `prog_words` is 0xFFFF.
- R2: The sequence is: data 0xAA at low address 0x555, then 0x55 at 0x2AA, then 0x25 at a sector address, then count N (0..15) at the same sector, then N+1 word writes, then 0x29 at the same sector. This sequence makes `prog_start` high for exactly the one cycle after the confirm write. At that point `page_base` equals the first loaded address with bits [3:0] cleared. Unlock writes compare only address bits [11:0] and data bits [7:0]. The sector is address bits [21:15].
- R3: A word loaded at address A is placed in `prog_words[16*A[3:0] +: 16]`. When an offset is loaded more than once, the later write wins. The load code clears every offset to 0xFFFF first.
- R4: A count value above 15 sets `aborted` one cycle after that write.
- R5: A loaded address whose bits [21:4] differ from those of the first loaded address sets `aborted`.
- R6: A count or confirm write to a sector other than the one given with 0x25 sets `aborted`. So does a first loaded address outside that sector.
- R7: After the last word, any write other than 0x29 to the sector sets `aborted` and raises no `prog_start`.
- R8: While aborted, a complete program sequence raises no `prog_start` and `aborted` stays high. Only 0xAA at 0x555, 0x55 at 0x2AA, then 0xF0 at 0x555 clears it, one cycle after the last of those writes. A wrong write inside that reset sequence leaves `aborted` high.
- R9: A wrong write during the unlock pair returns the block to idle without setting `aborted`. A following complete sequence then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | 22 | Write word address |
| wr_data | input | 16 | Write data |
| prog_start | output | 1 | One-cycle programming request |
| page_base | output | 22 | Page base address of the request |
| prog_words | output | 256 | Page buffer, offset k in bits [16k+15:16k] |
| aborted | output | 1 | Buffer load aborted, awaiting the abort reset |

## Verification
Every result is registered and appears one cycle after the write that causes it. This holds for `prog_start` after the confirm write, for `aborted` after the offending write, and for its clearing after the 0xF0 write. It holds equally for each buffer word after its load write. The bench drives each write for one clock and samples at the falling edge that follows the capturing edge, so it reads exactly that cycle's result. One further cycle later it confirms that `prog_start` has dropped again. Random legal loads are compared with a bench page model. Directed writes cover each abort cause, the ignored traffic while aborted, and the broken unlock and broken reset sequences.

// File: rtl/wbl_pkg.sv
package wbl_pkg;
  localparam logic [7:0] CMD_UNL1  = 8'hAA;
  localparam logic [7:0] CMD_UNL2  = 8'h55;
  localparam logic [7:0] CMD_LOAD  = 8'h25;
  localparam logic [7:0] CMD_CONF  = 8'h29;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [11:0] UNL_A1   = 12'h555;
  localparam logic [11:0] UNL_A2   = 12'h2AA;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_COUNT, S_LOAD, S_CONF, S_ABORT, S_ABT1, S_ABT2
  } seq_state_t;
endpackage

// File: rtl/wbl_buffer.sv
module wbl_buffer #(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 16,
  localparam int OFF_W     = $clog2(PAGE_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         we,
  input  logic [OFF_W-1:0]             idx,
  input  logic [DATA_W-1:0]            din,
  output logic [PAGE_WORDS*DATA_W-1:0] words
);
  logic [DATA_W-1:0] mem [PAGE_WORDS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < PAGE_WORDS; i++) mem[i] <= '1;
    end else if (we) begin
      mem[idx] <= din;
    end
  end

  for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_flat
    assign words[g*DATA_W +: DATA_W] = mem[g];
  end

  // R3: a clear leaves the top offset unprogrammed on the next cycle
  a_r3_clear_fill: assert property (@(posedge clk) disable iff (rst)
    clr |=> (words[PAGE_WORDS*DATA_W-1 -: DATA_W] == '1));
  // R3: a write lands at its offset
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> (words[$past(idx)*DATA_W +: DATA_W] == $past(din)));
endmodule

// File: rtl/wbl_fsm.sv
module wbl_fsm
  import wbl_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 16,
  parameter int SECT_LSB   = 15,
  localparam int OFF_W     = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              buf_clr,
  output logic              buf_we,
  output logic              prog_start,
  output logic [ADDR_W-1:0] page_base,
  output logic              aborted
);
  seq_state_t state;
  logic [ADDR_W-SECT_LSB-1:0] sect;
  logic [ADDR_W-OFF_W-1:0]    page;
  logic [OFF_W-1:0]           left;
  logic                       first;

  logic hit1, hit2, hit_rst, in_sect, in_page, load_ok, cnt_ok;
  always_comb begin
    hit1    = wr_addr[11:0] == UNL_A1 && wr_data[7:0] == CMD_UNL1;
    hit2    = wr_addr[11:0] == UNL_A2 && wr_data[7:0] == CMD_UNL2;
    hit_rst = wr_addr[11:0] == UNL_A1 && wr_data[7:0] == CMD_RESET;
    in_sect = wr_addr[ADDR_W-1:SECT_LSB] == sect;
    in_page = wr_addr[ADDR_W-1:OFF_W] == page;
    load_ok = first ? in_sect : in_page;
    cnt_ok  = in_sect && (wr_data < DATA_W'(PAGE_WORDS));
    buf_clr = wr_en && state == S_UNL2 && wr_data[7:0] == CMD_LOAD;
    buf_we  = wr_en && state == S_LOAD && load_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      sect       <= '0;
      page       <= '0;
      left       <= '0;
      first      <= 1'b0;
      prog_start <= 1'b0;
      page_base  <= '0;
      aborted    <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      if (wr_en) begin
        unique case (state)
          S_IDLE:  if (hit1) state <= S_UNL1;
          S_UNL1:  state <= hit2 ? S_UNL2 : S_IDLE;
          S_UNL2:  begin
            if (wr_data[7:0] == CMD_LOAD) begin
              state <= S_COUNT;
              sect  <= wr_addr[ADDR_W-1:SECT_LSB];
            end else state <= S_IDLE;
          end
          S_COUNT: begin
            if (cnt_ok) begin
              state <= S_LOAD;
              left  <= wr_data[OFF_W-1:0];
              first <= 1'b1;
            end else begin
              state <= S_ABORT;
              aborted <= 1'b1;
            end
          end
          S_LOAD:  begin
            if (load_ok) begin
              first <= 1'b0;
              if (first) page <= wr_addr[ADDR_W-1:OFF_W];
              if (left == '0) state <= S_CONF;
              else left <= left - 1'b1;
            end else begin
              state <= S_ABORT;
              aborted <= 1'b1;
            end
          end
          S_CONF:  begin
            if (in_sect && wr_data[7:0] == CMD_CONF) begin
              state      <= S_IDLE;
              prog_start <= 1'b1;
              page_base  <= {page, {OFF_W{1'b0}}};
            end else begin
              state <= S_ABORT;
              aborted <= 1'b1;
            end
          end
          S_ABORT: if (hit1) state <= S_ABT1;
          S_ABT1:  state <= hit2 ? S_ABT2 : S_ABORT;
          S_ABT2:  begin
            if (hit_rst) begin
              state   <= S_IDLE;
              aborted <= 1'b0;
            end else state <= S_ABORT;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);
  a_r4_count_abort: assert property (@(posedge clk) disable iff (rst)
    (state == S_COUNT && wr_en && wr_data >= DATA_W'(PAGE_WORDS)) |=> aborted);
  a_r5_page_abort: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD && wr_en && !first && !in_page) |=> aborted);
  a_r7_confirm_abort: assert property (@(posedge clk) disable iff (rst)
    (state == S_CONF && wr_en && wr_data[7:0] != CMD_CONF) |=> (aborted && !prog_start));
  a_r8_hold_abort: assert property (@(posedge clk) disable iff (rst)
    (aborted && !wr_en) |=> aborted);
  a_r8_no_start: assert property (@(posedge clk) disable iff (rst)
    aborted |-> !prog_start);
  a_r8_clear_path: assert property (@(posedge clk) disable iff (rst)
    $fell(aborted) |-> $past(state) == S_ABT2);
endmodule

// File: rtl/wbuf_loader.sv
module wbuf_loader #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 16,
  parameter int SECT_LSB   = 15,
  localparam int OFF_W     = $clog2(PAGE_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic                         prog_start,
  output logic [ADDR_W-1:0]            page_base,
  output logic [PAGE_WORDS*DATA_W-1:0] prog_words,
  output logic                         aborted
);
  logic buf_clr, buf_we;

  wbl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS),
            .SECT_LSB(SECT_LSB)) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_clr(buf_clr), .buf_we(buf_we), .prog_start(prog_start),
    .page_base(page_base), .aborted(aborted)
  );

  wbl_buffer #(.DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we),
    .idx(wr_addr[OFF_W-1:0]), .din(wr_data), .words(prog_words)
  );

  // R1: nothing is requested in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!prog_start && !aborted));
endmodule

// File: tb/wbuf_loader_test.sv
module wbuf_loader_test;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic prog_start, aborted;
  logic [21:0] page_base;
  logic [255:0] prog_words;
  int tests = 0, fails = 0, cycles = 0;
  logic [15:0] exp_w [16];

  always #4 clk = ~clk;

  wbuf_loader uut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_start(prog_start), .page_base(page_base),
    .prog_words(prog_words), .aborted(aborted));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic unlock(input logic [9:0] hi);
    wr({hi, 12'h555}, 16'h00AA);
    wr({hi, 12'h2AA}, 16'h0055);
  endtask

  function automatic logic [21:0] sa(input logic [6:0] s);
    return {s, 15'h0123};
  endfunction

  task automatic legal_run(input bit expect_ok);
    logic [6:0] s; logic [10:0] pg; logic [3:0] n, off; logic [15:0] d;
    s = 7'($urandom); pg = 11'($urandom); n = 4'($urandom);
    for (int k = 0; k < 16; k++) exp_w[k] = 16'hFFFF;
    unlock(10'($urandom));
    wr(sa(s), 16'h0025);
    wr(sa(s), {12'h0, n});
    for (int i = 0; i <= int'(n); i++) begin
      off = 4'($urandom); d = 16'($urandom);
      exp_w[off] = d;
      wr({s, pg, off}, d);
    end
    wr(sa(s), 16'h0029);
    if (expect_ok) begin
      chk(prog_start === 1'b1, "R2 start", 32'(prog_start), 1);
      chk(page_base === {s, pg, 4'h0}, "R2 page_base", 32'(page_base), 32'({s, pg, 4'h0}));
      chk(aborted === 1'b0, "R2 no abort", 32'(aborted), 0);
      for (int k = 0; k < 16; k++)
        chk(prog_words[16*k +: 16] === exp_w[k], "R3 word",
            32'(prog_words[16*k +: 16]), 32'(exp_w[k]));
      @(negedge clk);
      chk(prog_start === 1'b0, "R2 one-cycle", 32'(prog_start), 0);
    end else begin
      chk(prog_start === 1'b0, "R8 no start while aborted", 32'(prog_start), 0);
      chk(aborted === 1'b1, "R8 still aborted", 32'(aborted), 1);
    end
  endtask

  task automatic abort_reset();
    wr(22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
    wr(22'h000555, 16'h00F0);
    chk(aborted === 1'b0, "R8 abort cleared", 32'(aborted), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(prog_start === 0, "R1 start low", 32'(prog_start), 0);
    chk(aborted === 0, "R1 abort low", 32'(aborted), 0);
    chk(prog_words === {256{1'b1}}, "R1 words all ones", prog_words[31:0], 32'hFFFFFFFF);

    for (int t = 0; t < 40; t++) legal_run(1);

    // R4: count 16 and random larger
    unlock(0); wr(sa(7'd3), 16'h0025); wr(sa(7'd3), 16'd16);
    chk(aborted === 1, "R4 count 16", 32'(aborted), 1);
    legal_run(0);
    abort_reset();
    for (int t = 0; t < 5; t++) begin
      unlock(0); wr(sa(7'd5), 16'h0025); wr(sa(7'd5), 16'(16 + $urandom % 65000));
      chk(aborted === 1, "R4 large count", 32'(aborted), 1);
      abort_reset();
    end

    // R5: out-of-page second address
    unlock(0); wr(sa(7'd9), 16'h0025); wr(sa(7'd9), 16'd2);
    wr({7'd9, 11'd40, 4'd1}, 16'h1111);
    chk(aborted === 0, "R5 first in page", 32'(aborted), 0);
    wr({7'd9, 11'd41, 4'd2}, 16'h2222);
    chk(aborted === 1, "R5 out of page", 32'(aborted), 1);
    abort_reset();

    // R6: wrong sector on count, confirm, first address
    unlock(0); wr(sa(7'd9), 16'h0025); wr(sa(7'd10), 16'd0);
    chk(aborted === 1, "R6 count sector", 32'(aborted), 1);
    abort_reset();
    unlock(0); wr(sa(7'd9), 16'h0025); wr(sa(7'd9), 16'd0);
    wr({7'd8, 11'd1, 4'd0}, 16'h1234);
    chk(aborted === 1, "R6 first addr sector", 32'(aborted), 1);
    abort_reset();
    unlock(0); wr(sa(7'd9), 16'h0025); wr(sa(7'd9), 16'd0);
    wr({7'd9, 11'd1, 4'd0}, 16'h1234); wr(sa(7'd11), 16'h0029);
    chk(aborted === 1 && prog_start === 0, "R6 confirm sector", 32'({aborted, prog_start}), 2);
    abort_reset();

    // R7: wrong code after last word
    unlock(0); wr(sa(7'd2), 16'h0025); wr(sa(7'd2), 16'd1);
    wr({7'd2, 11'd7, 4'd3}, 16'h0A0A); wr({7'd2, 11'd7, 4'd4}, 16'h0B0B);
    wr(sa(7'd2), 16'h0030);
    chk(aborted === 1 && prog_start === 0, "R7 wrong confirm", 32'({aborted, prog_start}), 2);
    // R8: broken reset sequence keeps the abort
    wr(22'h000555, 16'h00AA); wr(22'h0002AA, 16'h0055); wr(22'h000556, 16'h00F0);
    chk(aborted === 1, "R8 bad reset addr", 32'(aborted), 1);
    wr(22'h000555, 16'h00AA); wr(22'h000555, 16'h00F0);
    chk(aborted === 1, "R8 skipped unlock", 32'(aborted), 1);
    legal_run(0);
    abort_reset();

    // R9: broken unlock then a good sequence
    wr(22'h000555, 16'h00AA); wr(22'h0002AA, 16'h0011);
    chk(aborted === 0, "R9 broken unlock no abort", 32'(aborted), 0);
    wr(22'h000555, 16'h00AA); wr(22'h0002AB, 16'h0055);
    chk(aborted === 0 && prog_start === 0, "R9 bad addr idle", 32'({aborted, prog_start}), 0);
    legal_run(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule